// File: doc/BRIEF.md
# 64B/66B Transmit Block Encoder with Payload Scrambler

This block turns a 64-bit parallel transmit word (eight bytes, each with its own control flag) into a 66-bit line block. A word with no control flags becomes a data block. A word that carries control characters becomes a control block. A control block starts with an 8-bit block type and then holds data bytes and 7-bit control codes, packed according to where the start or terminate character sits in the word. The 64-bit payload then passes through a self-synchronous scrambler built on x^58 + x^39 + 1. The 2-bit sync header bypasses the scrambler, so a receiver can find block boundaries before it descrambles.

A word is accepted on any cycle where `in_valid` is high. The block appears on the outputs one clock later with `out_valid` set. Cycles without `in_valid` leave the scrambler state as it was. A gearbox and a serializer downstream take the 66-bit blocks.

Input control characters are recognised by value: idle 0x07, start 0xFB, terminate 0xFD, error 0xFE. In all payload layouts, payload bit 0 is the first bit sent and the type byte occupies payload bits 7:0.

Top module: `pcs66_tx_encoder`

## Requirements
- R1: A word whose eight control flags are all 0 yields sync header 01, and its unscrambled payload is the input word unchanged, with lane 0 in bits 7:0 and lane 7 in bits 63:56.
- R2: A word with at least one control flag set yields sync header 10. The headers 00 and 11 never appear while `out_valid` is high.
- R3: The scrambler has 58 state bits, all 1 after reset. Payload bits are processed from bit 0 upward: out = in ^ s[38] ^ s[57], then s = {s[56:0], out}. The state advances only on cycles where `in_valid` is high, and cycles without it change neither the state nor the outputs.
- R4: The sync header is sent unscrambled, and a descrambler that observes only the output recovers the data of every data block.
- R5: A word of eight control lanes, each holding idle (0x07) or error (0xFE), becomes type 0x1E. Lane i's code sits at payload bits 8+7i to 14+7i, with idle coded as 0x00 and error as 0x1E.
- R6: A word whose only control lane is lane 0 and which holds start (0xFB) there becomes type 0x78, with data lanes 1 to 7 at payload bits 15:8 up to 63:56.
- R7: A word with a terminate (0xFD) in lane k (0 to 7), data in every lane below k, and idle or error in every lane above k becomes a type from 0x87, 0x99, 0xAA, 0xB4, 0xCC, 0xD2, 0xE1, 0xFF (indexed by k). The payload holds, in this order: the type byte; data lanes 0 to k-1 at 8 bits each; 7-k zero bits; then the 7-bit codes of lanes k+1 to 7.
- R8: Any other word that has a control flag set becomes type 0x1E with all eight codes equal to 0x1E. This covers words with unknown control values, a start outside lane 0, data after a terminate, and similar cases.
- R9: The output block is registered one cycle after the input. `out_valid` equals `in_valid` from the previous cycle, and `out_valid` is 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present this cycle |
| in_data | input | 64 | Eight input bytes, lane 0 in bits 7:0 |
| in_ctrl | input | 8 | Per-lane control flag, bit i for lane i |
| out_valid | output | 1 | Output block present |
| out_hdr | output | 2 | Unscrambled sync header |
| out_payload | output | 64 | Scrambled payload, bit 0 sent first |

## Verification
Some properties are checked by assertions on every cycle:
- the header is legal;
- the header follows the control flags;
- the output timing matches the input timing;
- idle cycles change nothing;
- a descrambler fed only from the outputs recovers each data word (this ties the scrambler taps and bit order to the header path).

The exact block type and the lane packing for idle, start, each of the eight terminate positions and the fallback error block are shown only by the bench scenarios. They come from comparing every scrambled block against a separately written encoder and scrambler model.

// File: rtl/pcs66_pkg.sv
package pcs66_pkg;
    localparam int LANES   = 8;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = LANES * BYTE_W;
    localparam int CODE_W  = 7;
    localparam int TYPE_W  = 8;
    localparam int HDR_W   = 2;
    localparam int SCR_LEN = 58;
    localparam int TAP_A   = 38;
    localparam int TAP_B   = 57;

    localparam logic [HDR_W-1:0] HDR_DATA = 2'b01;
    localparam logic [HDR_W-1:0] HDR_CTRL = 2'b10;

    localparam logic [BYTE_W-1:0] CH_IDLE  = 8'h07;
    localparam logic [BYTE_W-1:0] CH_START = 8'hFB;
    localparam logic [BYTE_W-1:0] CH_TERM  = 8'hFD;
    localparam logic [BYTE_W-1:0] CH_ERR   = 8'hFE;

    localparam logic [CODE_W-1:0] CODE_IDLE = 7'h00;
    localparam logic [CODE_W-1:0] CODE_ERR  = 7'h1E;

    localparam logic [TYPE_W-1:0] TY_CTRL  = 8'h1E;
    localparam logic [TYPE_W-1:0] TY_START = 8'h78;

    typedef struct packed {
        logic [HDR_W-1:0]  hdr;
        logic [WORD_W-1:0] body;
    } block_t;

    function automatic logic [TYPE_W-1:0] term_type(input int k);
        case (k)
            0:       return 8'h87;
            1:       return 8'h99;
            2:       return 8'hAA;
            3:       return 8'hB4;
            4:       return 8'hCC;
            5:       return 8'hD2;
            6:       return 8'hE1;
            default: return 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/pcs66_classify.sv
module pcs66_classify
    import pcs66_pkg::*;
(
    input  logic [WORD_W-1:0] txd,
    input  logic [LANES-1:0]  txc,
    output block_t            blk
);
    logic [LANES-1:0]  quiet;
    logic [CODE_W-1:0] code [LANES];
    logic [LANES-1:0]  term_hit;
    logic [WORD_W-1:0] term_body [LANES];
    logic [WORD_W-1:0] ctrl_body;

    // per-lane decode of control characters into 7-bit codes
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [BYTE_W-1:0] b;
        assign b        = txd[i*BYTE_W +: BYTE_W];
        assign quiet[i] = txc[i] && (b == CH_IDLE || b == CH_ERR);
        assign code[i]  = (b == CH_IDLE) ? CODE_IDLE : CODE_ERR;
    end

    always_comb begin
        ctrl_body = '0;
        ctrl_body[TYPE_W-1:0] = TY_CTRL;
        for (int i = 0; i < LANES; i++) begin
            ctrl_body[TYPE_W + CODE_W*i +: CODE_W] = code[i];
        end
    end

    // one candidate layout per terminate position
    for (genvar k = 0; k < LANES; k++) begin : g_term
        localparam logic [LANES-1:0] LOW_MASK  = LANES'((1 << k) - 1);
        localparam logic [LANES-1:0] HIGH_MASK = ~LANES'((1 << (k + 1)) - 1);
        localparam int CODE_BASE = TYPE_W + BYTE_W*k + (LANES - 1 - k);

        assign term_hit[k] = ((txc & LOW_MASK) == '0) && txc[k]
                           && (txd[k*BYTE_W +: BYTE_W] == CH_TERM)
                           && (((quiet | ~HIGH_MASK)) == '1);

        always_comb begin
            term_body[k] = '0;
            term_body[k][TYPE_W-1:0] = term_type(k);
            for (int j = 0; j < k; j++) begin
                term_body[k][TYPE_W + BYTE_W*j +: BYTE_W] = txd[BYTE_W*j +: BYTE_W];
            end
            for (int j = k + 1; j < LANES; j++) begin
                term_body[k][CODE_BASE + CODE_W*(j-k-1) +: CODE_W] = code[j];
            end
        end
    end

    always_comb begin
        blk.hdr  = HDR_CTRL;
        blk.body = {{LANES{CODE_ERR}}, TY_CTRL};
        if (txc == '0) begin
            blk.hdr  = HDR_DATA;
            blk.body = txd;
        end else if (quiet == '1) begin
            blk.body = ctrl_body;
        end else if (txc == LANES'(1) && txd[BYTE_W-1:0] == CH_START) begin
            blk.body = {txd[WORD_W-1:BYTE_W], TY_START};
        end else begin
            for (int k = LANES - 1; k >= 0; k--) begin
                if (term_hit[k]) blk.body = term_body[k];
            end
        end
    end
endmodule

// File: rtl/pcs66_scrambler.sv
module pcs66_scrambler
    import pcs66_pkg::*;
(
    input  logic [SCR_LEN-1:0] state_i,
    input  logic [WORD_W-1:0]  data_i,
    output logic [WORD_W-1:0]  data_o,
    output logic [SCR_LEN-1:0] state_o
);
    always_comb begin
        logic [SCR_LEN-1:0] s;
        logic               o;
        s      = state_i;
        data_o = '0;
        for (int i = 0; i < WORD_W; i++) begin
            o         = data_i[i] ^ s[TAP_A] ^ s[TAP_B];
            data_o[i] = o;
            s         = {s[SCR_LEN-2:0], o};
        end
        state_o = s;
    end
endmodule

// File: rtl/pcs66_tx_encoder.sv
module pcs66_tx_encoder
    import pcs66_pkg::*;
#(
    parameter logic [SCR_LEN-1:0] SCR_SEED = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic [LANES-1:0]  in_ctrl,
    output logic              out_valid,
    output logic [HDR_W-1:0]  out_hdr,
    output logic [WORD_W-1:0] out_payload
);
    typedef struct packed {
        logic               vld;
        logic [HDR_W-1:0]   hdr;
        logic [WORD_W-1:0]  pay;
        logic [SCR_LEN-1:0] scr;
    } enc_state_t;

    enc_state_t st_d, st_q;
    block_t             blk;
    logic [WORD_W-1:0]  scr_data;
    logic [SCR_LEN-1:0] scr_next;

    pcs66_classify u_classify (
        .txd (in_data),
        .txc (in_ctrl),
        .blk (blk)
    );

    pcs66_scrambler u_scrambler (
        .state_i (st_q.scr),
        .data_i  (blk.body),
        .data_o  (scr_data),
        .state_o (scr_next)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.hdr = blk.hdr;
            st_d.pay = scr_data;
            st_d.scr = scr_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.vld <= 1'b0;
            st_q.hdr <= HDR_CTRL;
            st_q.pay <= '0;
            st_q.scr <= SCR_SEED;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.vld;
    assign out_hdr     = st_q.hdr;
    assign out_payload = st_q.pay;
endmodule

// File: rtl/pcs66_tx_checks.sv
module pcs66_tx_checks
    import pcs66_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] in_data,
    input logic [LANES-1:0]  in_ctrl,
    input logic              out_valid,
    input logic [HDR_W-1:0]  out_hdr,
    input logic [WORD_W-1:0] out_payload
);
    logic [SCR_LEN-1:0] ds_q;
    logic [WORD_W-1:0]  prev_data_q;
    logic               synced_q;
    logic [WORD_W-1:0]  descr;
    logic [SCR_LEN-1:0] ds_next;

    // receive-side descrambler driven only from the block outputs
    always_comb begin
        logic [SCR_LEN-1:0] s;
        s     = ds_q;
        descr = '0;
        for (int i = 0; i < WORD_W; i++) begin
            descr[i] = out_payload[i] ^ s[TAP_A] ^ s[TAP_B];
            s        = {s[SCR_LEN-2:0], out_payload[i]};
        end
        ds_next = s;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ds_q        <= '0;
            prev_data_q <= '0;
            synced_q    <= 1'b0;
        end else begin
            if (out_valid) begin
                ds_q     <= ds_next;
                synced_q <= 1'b1;
            end
            if (in_valid) prev_data_q <= in_data;
        end
    end

    // R2
    legal_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_hdr == HDR_DATA || out_hdr == HDR_CTRL));

    // R1
    data_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ctrl == '0) |=> (out_hdr == HDR_DATA));

    // R2
    ctrl_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ctrl != '0) |=> (out_hdr == HDR_CTRL));

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_payload) && $stable(out_hdr)));

    // R4
    descramble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && synced_q && out_hdr == HDR_DATA) |-> (descr == prev_data_q));
endmodule

bind pcs66_tx_encoder pcs66_tx_checks u_checks (.*);

// File: tb/pcs66_tx_encoder_test.sv
module pcs66_tx_encoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic [7:0]  in_ctrl = '0;
    logic        out_valid;
    logic [1:0]  out_hdr;
    logic [63:0] out_payload;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [1:0]  hdr;
        logic [63:0] pay;
        string       tag;
    } exp_t;
    exp_t exp_q [$];

    logic [57:0] model_s = '1;

    always #4 clk = ~clk;

    pcs66_tx_encoder uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ctrl(in_ctrl), .out_valid(out_valid), .out_hdr(out_hdr),
        .out_payload(out_payload)
    );

    function automatic logic [6:0] m_code(input logic [7:0] b);
        return (b == 8'h07) ? 7'h00 : 7'h1E;
    endfunction

    function automatic bit m_quiet(input logic [7:0] b, input logic c);
        return c && (b == 8'h07 || b == 8'hFE);
    endfunction

    // reference encoder: builds the payload by appending fields at a pointer
    function automatic logic [65:0] m_encode(input logic [63:0] d, input logic [7:0] c);
        logic [7:0]  types [8];
        logic [7:0]  b [8];
        logic [63:0] body;
        int          ptr;
        int          t;
        bit          ok;
        types = '{8'h87, 8'h99, 8'hAA, 8'hB4, 8'hCC, 8'hD2, 8'hE1, 8'hFF};
        for (int i = 0; i < 8; i++) b[i] = d[8*i +: 8];
        if (c == 8'h00) return {2'b01, d};
        ok = 1'b1;
        for (int i = 0; i < 8; i++) if (!m_quiet(b[i], c[i])) ok = 1'b0;
        if (ok) begin
            body = '0; body[7:0] = 8'h1E; ptr = 8;
            for (int i = 0; i < 8; i++) begin body[ptr +: 7] = m_code(b[i]); ptr += 7; end
            return {2'b10, body};
        end
        if (c == 8'h01 && b[0] == 8'hFB) return {2'b10, d[63:8], 8'h78};
        t = 0;
        while (!c[t]) t++;
        ok = (b[t] == 8'hFD);
        for (int i = t + 1; i < 8; i++) if (!m_quiet(b[i], c[i])) ok = 1'b0;
        if (ok) begin
            body = '0; body[7:0] = types[t]; ptr = 8;
            for (int i = 0; i < t; i++) begin body[ptr +: 8] = b[i]; ptr += 8; end
            ptr += 7 - t;
            for (int i = t + 1; i < 8; i++) begin body[ptr +: 7] = m_code(b[i]); ptr += 7; end
            return {2'b10, body};
        end
        body = {{8{7'h1E}}, 8'h1E};
        return {2'b10, body};
    endfunction

    function automatic logic [63:0] m_scramble(input logic [63:0] x);
        logic [63:0] y;
        logic        o;
        for (int i = 0; i < 64; i++) begin
            o       = x[i] ^ model_s[38] ^ model_s[57];
            y[i]    = o;
            model_s = {model_s[56:0], o};
        end
        return y;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [65:0] act,
                         input logic [65:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [63:0] d, input logic [7:0] c, input string tag);
        logic [65:0] e;
        exp_t        item;
        @(negedge clk);
        e        = m_encode(d, c);
        item.hdr = e[65:64];
        item.pay = m_scramble(e[63:0]);
        item.tag = tag;
        exp_q.push_back(item);
        in_valid = 1'b1;
        in_data  = d;
        in_ctrl  = c;
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = {16{4'hA ^ 4'(i)}};
            in_ctrl  = 8'(i * 37);
        end
    endtask

    function automatic logic [63:0] term_word(input int k, input logic [7:0] fill);
        logic [63:0] d;
        for (int i = 0; i < 8; i++)
            d[8*i +: 8] = (i < k) ? 8'(fill + i) : ((i == k) ? 8'hFD : 8'h07);
        return d;
    endfunction

    // monitor: compares every produced block against the queue head
    initial begin
        exp_t item;
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && out_valid && !done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected block", {out_hdr, out_payload}, '0);
                end else begin
                    item = exp_q.pop_front();
                    check({out_hdr, out_payload} == {item.hdr, item.pay}, item.tag,
                          {out_hdr, out_payload}, {item.hdr, item.pay});
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R9 reset out_valid", {65'b0, out_valid}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(out_valid == 1'b0, "R9 idle after reset", {65'b0, out_valid}, '0);

        send(64'h0706050403020100, 8'h00, "R1 data block");
        send(64'hFFFFFFFFFFFFFFFF, 8'h00, "R1 data all ones R3");
        send(64'h0000000000000000, 8'h00, "R4 data zeros");
        send({8{8'h07}}, 8'hFF, "R5 all idle");
        send({8'h07, 8'hFE, 8'h07, 8'h07, 8'hFE, 8'h07, 8'h07, 8'h07}, 8'hFF, "R5 idle error mix");
        send({56'h66554433221100, 8'hFB}, 8'h01, "R6 start block");
        gap(3);
        send(64'h1122334455667788, 8'h00, "R3 data after gap");
        for (int k = 0; k < 8; k++) begin
            send(term_word(k, 8'h30 + 8'(k)), 8'hFF << k, $sformatf("R7 terminate lane %0d", k));
        end
        send({{7{8'h07}}, 8'h9C}, 8'hFF, "R8 unknown control");
        send({{4{8'h55}}, 8'hFB, {3{8'h44}}}, 8'h08, "R8 start in lane 3");
        send({8'h99, 8'h07, 8'hFD, 8'h42, 40'h1122334455}, 8'h60, "R8 data after terminate");
        send(64'hDEADBEEFCAFEF00D, 8'h00, "R2 R1 data after control");
        gap(1);
        send({8'hFE, {6{8'h07}}, 8'hFD}, 8'hFF, "R7 terminate lane 0 error tail");
        gap(4);
        check(exp_q.size() == 0, "R9 all blocks produced", 66'(exp_q.size()), '0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule